// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Four-Word Line Refill

This block is the instruction cache of a 32-bit processor. The fetch unit presents a word address, and one cycle later the cache answers with a hit flag and the instruction word. On a miss, the cache raises its stall output. It then asks the bus interface for the whole 16-byte line that holds the word, as a single four-word read. It writes the returned words into its data array as they arrive. Only after the last of the four words does it mark the line valid and release the stall. The fetch unit then presents the address again.

The arrays are indexed and tagged with physical addresses, so any word of the 4 GB space can be cached. No flush is needed when the software context changes. Capacity is a parameter of 4 KB or 8 KB. Each address maps to exactly one line. An invalidate-all input clears the valid flags one line per cycle. The same sweep runs after reset, because the tag array is a plain synchronous RAM with no reset.

Top module: `icache_dm`

## Requirements
- R1: While reset is high, and for exactly LINES cycles after it falls (LINES = capacity/16, which is 256 at 4 KB), stall is 1 and hit is 0. After that sweep, every fetch misses.
- R2: When fetch_req is 1 at a clock edge and the addressed line is valid with a matching tag, then in the next cycle hit is 1, stall is 0 and rdata holds the stored word.
- R3: When a fetch misses, stall is 1 in the cycle after the address is taken. From the following cycle on, refill_req is 1 and refill_addr is the line-aligned word address: the fetched address with bits [1:0] cleared.
- R4: Refill words are taken only in cycles where refill_valid is 1, in ascending word order. Idle cycles between words are allowed. stall and refill_req stay 1, and refill_addr stays stable, until the fourth word has been written. After that, both stall and refill_req fall.
- R5: After a refill, all four words of the line hit and return the words the bus supplied.
- R6: Mapping is direct. Word-address bits [1:0] select the word within the line. Bits [IDX+1:2] select the line, where IDX is 8 at 4 KB and 9 at 8 KB. The remaining upper bits form the tag. A fetch with the same index and a different tag misses and replaces the line, and the old address then misses.
- R7: Any 30-bit word address can be cached, including all-zero and all-one addresses.
- R8: A pulse on inv_all while the cache is idle holds stall at 1 for exactly LINES cycles. After that, every line previously cached misses.
- R9: An inv_all pulse that arrives during a refill is held until the fourth word is written. Stall then continues without a gap through a full LINES-cycle sweep, and the freshly filled line misses afterwards.
- R10: With fetch_req at 0, hit, stall and refill_req stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts an invalidate sweep |
| fetch_req | input | 1 | A fetch address is presented this cycle |
| fetch_addr | input | 30 | Physical word address of the fetch |
| hit | output | 1 | Lookup of the previous cycle hit; rdata is valid |
| rdata | output | 32 | Instruction word for a hit |
| stall | output | 1 | Lookup missed, refill in progress, or invalidate sweep running |
| inv_all | input | 1 | Request to invalidate every line |
| refill_req | output | 1 | Four-word line read requested from the bus interface |
| refill_addr | output | 30 | Line-aligned word address of the requested line |
| refill_valid | input | 1 | A refill word is on refill_data this cycle |
| refill_data | input | 32 | Refill word, in ascending word order |

## Verification
The bench builds the cache at its 4 KB setting. At that size the index sweep is short enough to fill every one of the 256 lines with a miss and then read back all four words of each line. A tag of 20 bits lets aliasing addresses exactly 4 KB apart be reached directly. This also brings within reach the extreme addresses at both ends of the 30-bit word space. Every expected word is computed arithmetically from its address, and the length of each invalidate sweep is counted cycle by cycle.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    ST_SWEEP = 2'd0,
    ST_READY = 2'd1,
    ST_FILL  = 2'd2
  } ic_state_t;

  localparam int WORD_AW    = 30;
  localparam int OFS_W      = 2;
  localparam int LINE_WORDS = 4;
endpackage

// File: rtl/icache_sram.sv
module icache_sram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int LINES = 256,
  localparam int IDX_W  = $clog2(LINES),
  localparam int LINE_W = WORD_AW - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss,
  input  logic [LINE_W-1:0] miss_line,
  input  logic              inv_all,
  input  logic              refill_valid,
  output logic              ready,
  output logic              refill_req,
  output logic [LINE_W-1:0] line_q,
  output logic              tag_we,
  output logic [IDX_W-1:0]  tag_waddr,
  output logic              tag_wvalid,
  output logic              data_we,
  output logic [OFS_W-1:0]  word_cnt
);
  ic_state_t        state;
  logic [IDX_W-1:0] sweep_cnt;
  logic             inv_pend;
  logic             last_word;

  assign last_word  = refill_valid && (word_cnt == OFS_W'(LINE_WORDS - 1));
  assign ready      = (state == ST_READY);
  assign refill_req = (state == ST_FILL);
  assign data_we    = (state == ST_FILL) && refill_valid;

  always_comb begin
    tag_we     = 1'b0;
    tag_waddr  = line_q[IDX_W-1:0];
    tag_wvalid = 1'b0;
    if (state == ST_SWEEP) begin
      tag_we    = 1'b1;
      tag_waddr = sweep_cnt;
    end else if (state == ST_FILL && last_word) begin
      tag_we     = 1'b1;
      tag_wvalid = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_SWEEP;
      sweep_cnt <= '0;
      word_cnt  <= '0;
      inv_pend  <= 1'b0;
      line_q    <= '0;
    end else begin
      case (state)
        ST_SWEEP: begin
          sweep_cnt <= sweep_cnt + 1'b1;
          if (sweep_cnt == IDX_W'(LINES - 1)) begin
            state     <= ST_READY;
            sweep_cnt <= '0;
          end
        end
        ST_READY: begin
          if (inv_all) begin
            state <= ST_SWEEP;
          end else if (miss) begin
            state    <= ST_FILL;
            line_q   <= miss_line;
            word_cnt <= '0;
          end
        end
        ST_FILL: begin
          if (inv_all) inv_pend <= 1'b1;
          if (refill_valid) begin
            word_cnt <= word_cnt + 1'b1;
            if (last_word) begin
              state    <= (inv_pend || inv_all) ? ST_SWEEP : ST_READY;
              inv_pend <= 1'b0;
            end
          end
        end
        default: state <= ST_SWEEP;
      endcase
    end
  end
endmodule

// File: rtl/icache_dm.sv
module icache_dm
  import icache_pkg::*;
#(
  parameter int CACHE_KB = 4,
  localparam int LINES  = CACHE_KB * 1024 / (LINE_WORDS * 4),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = WORD_AW - OFS_W - IDX_W,
  localparam int LINE_W = WORD_AW - OFS_W,
  localparam int DAT_AW = IDX_W + OFS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_req,
  input  logic [WORD_AW-1:0] fetch_addr,
  output logic               hit,
  output logic [31:0]        rdata,
  output logic               stall,
  input  logic               inv_all,
  output logic               refill_req,
  output logic [WORD_AW-1:0] refill_addr,
  input  logic               refill_valid,
  input  logic [31:0]        refill_data
);
  logic              ready;
  logic              req_q;
  logic [TAG_W-1:0]  tag_q;
  logic [TAG_W:0]    tag_rd;
  logic              match;
  logic              miss;
  logic [LINE_W-1:0] line_q;
  logic              tag_we;
  logic [IDX_W-1:0]  tag_waddr;
  logic              tag_wvalid;
  logic              data_we;
  logic [OFS_W-1:0]  word_cnt;
  logic [WORD_AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      req_q <= fetch_req && ready;
      if (fetch_req && ready) addr_q <= fetch_addr;
    end
  end

  assign tag_q = addr_q[WORD_AW-1 -: TAG_W];

  icache_sram #(.WIDTH(TAG_W + 1), .DEPTH(LINES)) u_tags (
    .clk   (clk),
    .we    (tag_we),
    .waddr (tag_waddr),
    .wdata ({tag_wvalid, line_q[LINE_W-1 -: TAG_W]}),
    .re    (ready),
    .raddr (fetch_addr[OFS_W +: IDX_W]),
    .rdata (tag_rd)
  );

  icache_sram #(.WIDTH(32), .DEPTH(LINES * LINE_WORDS)) u_data (
    .clk   (clk),
    .we    (data_we),
    .waddr ({line_q[IDX_W-1:0], word_cnt}),
    .wdata (refill_data),
    .re    (ready),
    .raddr (fetch_addr[DAT_AW-1:0]),
    .rdata (rdata)
  );

  assign match = tag_rd[TAG_W] && (tag_rd[TAG_W-1:0] == tag_q);
  assign hit   = req_q && match && ready;
  assign miss  = req_q && !match && ready;
  assign stall = !ready || miss;
  assign refill_addr = {line_q, {OFS_W{1'b0}}};

  icache_ctrl #(.LINES(LINES)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .miss         (miss),
    .miss_line    (addr_q[WORD_AW-1:OFS_W]),
    .inv_all      (inv_all),
    .refill_valid (refill_valid),
    .ready        (ready),
    .refill_req   (refill_req),
    .line_q       (line_q),
    .tag_we       (tag_we),
    .tag_waddr    (tag_waddr),
    .tag_wvalid   (tag_wvalid),
    .data_we      (data_we),
    .word_cnt     (word_cnt)
  );
endmodule

// File: rtl/icache_dm_chk.sv
module icache_dm_chk (
  input logic        clk,
  input logic        rst,
  input logic        fetch_req,
  input logic        hit,
  input logic        stall,
  input logic        refill_req,
  input logic [29:0] refill_addr,
  input logic        refill_valid
);
  // R3
  line_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    refill_req |-> (refill_addr[1:0] == 2'b00));

  // R2
  hit_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> !stall);

  // R4
  refill_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (refill_req && !refill_valid) |=> (refill_req && $stable(refill_addr)));

  // R4
  refill_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    refill_req |-> stall);

  // R10
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(fetch_req));
endmodule

bind icache_dm icache_dm_chk u_chk (.*);

// File: tb/tb_icache_dm.sv
module tb_icache_dm;
  localparam int LINES = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_req = 1'b0;
  logic [29:0] fetch_addr = '0;
  logic        hit;
  logic [31:0] rdata;
  logic        stall;
  logic        inv_all = 1'b0;
  logic        refill_req;
  logic [29:0] refill_addr;
  logic        refill_valid = 1'b0;
  logic [31:0] refill_data = '0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  icache_dm #(.CACHE_KB(4)) dut (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .hit(hit), .rdata(rdata), .stall(stall), .inv_all(inv_all),
    .refill_req(refill_req), .refill_addr(refill_addr),
    .refill_valid(refill_valid), .refill_data(refill_data)
  );

  function automatic logic [31:0] memw(input logic [29:0] a);
    return ({a, 2'b01} * 32'h9E37_79B9) ^ 32'hC3A5_1F0E;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic count_sweep(input string req);
    int n = 0;
    while (stall && n < 2 * LINES) begin
      chk(!hit, req, 32'(hit), 32'd0);
      n++;
      @(negedge clk);
    end
    chk(n == LINES, req, 32'(n), 32'(LINES));
  endtask

  // fetch one word; on a miss serve the refill with 'gap' idle cycles per word
  task automatic fetch(input logic [29:0] a, input bit exp_hit, input int gap,
                       input bit inv_mid, input string req);
    logic [29:0] base;
    base = {a[29:2], 2'b00};
    fetch_req  = 1'b1;
    fetch_addr = a;
    @(negedge clk);
    fetch_req = 1'b0;
    if (exp_hit) begin
      chk(hit && !stall, req, {30'd0, hit, stall}, 32'h2);
      chk(rdata == memw(a), req, rdata, memw(a));
    end else begin
      chk(!hit && stall, req, {30'd0, hit, stall}, 32'h1);
      @(negedge clk);
      chk(refill_req == 1'b1, "R3", 32'(refill_req), 32'd1);
      chk(refill_addr == base, "R3", 32'(refill_addr), 32'(base));
      for (int i = 0; i < 4; i++) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          chk(stall && refill_req && refill_addr == base, "R4",
              {31'd0, stall}, 32'd1);
        end
        refill_valid = 1'b1;
        refill_data  = memw(base + 30'(i));
        if (inv_mid && i == 2) inv_all = 1'b1;
        @(negedge clk);
        inv_all      = 1'b0;
        refill_valid = 1'b0;
        if (i < 3) chk(stall && refill_req, "R4", {31'd0, stall}, 32'd1);
      end
      if (inv_mid) begin
        chk(refill_req == 1'b0, "R9", 32'(refill_req), 32'd0);
        count_sweep("R9");
      end else begin
        chk(!stall && !refill_req, "R4", {30'd0, stall, refill_req}, 32'd0);
      end
    end
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [29:0] a;
    logic [29:0] b;
    repeat (3) @(negedge clk);
    chk(stall && !hit && !refill_req, "R1", {29'd0, stall, hit, refill_req}, 32'h4);
    rst = 1'b0;
    count_sweep("R1");

    // R1/R3/R4/R5: fill every line, varying gap and starting word, then read all words back
    for (int l = 0; l < LINES; l++) begin
      a = {20'h01234, 8'(l), 2'(l % 4)};
      fetch(a, 1'b0, l % 3, 1'b0, "R3");
      for (int w = 0; w < 4; w++) fetch({a[29:2], 2'(w)}, 1'b1, 0, 1'b0, "R5");
    end
    // R2: hits stay hits on a second pass
    for (int l = 0; l < LINES; l += 17) fetch({20'h01234, 8'(l), 2'd3}, 1'b1, 0, 1'b0, "R2");

    // R6: alias at the same index, different tag
    a = {20'h01234, 8'd5, 2'd1};
    b = {20'h00077, 8'd5, 2'd1};
    fetch(b, 1'b0, 1, 1'b0, "R6");
    fetch(b, 1'b1, 0, 1'b0, "R6");
    fetch(a, 1'b0, 0, 1'b0, "R6");
    fetch(b, 1'b0, 0, 1'b0, "R6");
    fetch({20'h01234, 8'd6, 2'd0}, 1'b1, 0, 1'b0, "R6");

    // R7: extreme addresses
    fetch(30'h3FFF_FFFF, 1'b0, 2, 1'b0, "R7");
    fetch(30'h3FFF_FFFC, 1'b1, 0, 1'b0, "R7");
    fetch(30'h0000_0000, 1'b0, 0, 1'b0, "R7");
    fetch(30'h0000_0003, 1'b1, 0, 1'b0, "R7");

    // R10: no request, no activity
    fetch_addr = 30'h0000_0001;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!hit && !stall && !refill_req, "R10", {29'd0, hit, stall, refill_req}, 32'd0);
    end

    // R8: invalidate-all from idle
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    count_sweep("R8");
    fetch(30'h0000_0001, 1'b0, 0, 1'b0, "R8");
    fetch({20'h01234, 8'd9, 2'd2}, 1'b0, 0, 1'b0, "R8");
    fetch(30'h3FFF_FFFE, 1'b0, 0, 1'b0, "R8");

    // R9: invalidate arriving mid-refill
    a = {20'h0ABCD, 8'd200, 2'd2};
    fetch(a, 1'b0, 1, 1'b1, "R9");
    fetch(a, 1'b0, 0, 1'b0, "R9");
    fetch(a, 1'b1, 0, 1'b0, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule